// File: doc/BRIEF.md
# Open-Drain Pin Bank with Blink and Change-of-State Fault

This block manages a small bank of general purpose pins. Each pin has an open-drain pull-down. A per-pin output bit switches that pull-down: a bit of 1 releases the pin so that an external pull-up (or another driver) sets its level, and a bit of 0 pulls the pin low. The host reads one word that holds the live, synchronised pin levels next to the stored output bits. This lets the same pin serve as an LED driver or as a digital input.

Two options can be set on each pin. The first is a blink enable. When the pin is being pulled low, it gates the pull-down with a slow phase that is shared by all pins. The phase flips on every pulse of an external slow tick, so a tick near 3 Hz gives a blink of about 1.5 Hz, and every blinking pin stays in step. The second is a fault enable. It stores a reference level when the enable is turned on, and again on every fault-clear pulse. After that, any synchronised level that differs from the reference sets a sticky fault flag for that pin. Pads, LED current limiting and the serial bus that reaches these registers lie outside this block.

Top module: `opendrain_gpio`

## Requirements
- R1: After reset all output bits read 1, blink and fault enables are 0, the blink phase is 0, every pull-down is off and every fault flag is 0.
- R2: When blink is off for a pin, its pull-down (pullDown bit i = 1 means on) is on exactly when its output bit is 0. A write on outWrEn takes effect on the next clock edge.
- R3: readback bits [2N-1:N] hold the pin levels after a two-flop synchroniser, so a pin change shows up two clock edges later. Bits [N-1:0] hold the output bits.
- R4: With blink enabled and the output bit at 0, the pull-down is on only while the shared blink phase is 1. The phase flips on each clock edge where blinkTick is high, and all blinking pins follow the same phase.
- R5: With the output bit at 1, the pull-down stays off whatever the blink enable and the phase are.
- R6: When a pin's fault enable goes from 0 to 1 (through cfgWrEn), the synchronised pin level at that edge becomes the reference. A later input change away from the reference sets the pin's fault flag on the third clock edge after the change.
- R7: A fault flag stays set after the pin returns to its reference level, until it is cleared.
- R8: A faultClr pulse clears every fault flag and loads every reference with the current synchronised level. A later level that differs from that captured level raises the fault again.
- R9: Writing a pin's fault enable to 0 clears its flag on the next edge. While the enable is 0, pin changes raise no fault.
- R10: When faultClr arrives on the same edge that a mismatch would set a fault, the clear wins. The new level becomes the reference, so no fault follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blinkTick | input | 1 | One-cycle pulse that flips the shared blink phase |
| outWrEn | input | 1 | Write strobe for the output bits |
| outWrData | input | NUM_PINS | New output bits (1 releases the pin, 0 pulls it low) |
| cfgWrEn | input | 1 | Write strobe for the blink and fault enables |
| cfgBlink | input | NUM_PINS | New blink enables |
| cfgFaultEn | input | NUM_PINS | New fault enables |
| faultClr | input | 1 | One-cycle pulse that clears all faults and recaptures the references |
| pinIn | input | NUM_PINS | Raw pin levels from the pads |
| pullDown | output | NUM_PINS | Pull-down gate per pin, 1 = pulling low |
| readback | output | 2*NUM_PINS | Synchronised pin levels (upper half) and output bits (lower half) |
| faultFlags | output | NUM_PINS | Latched change-of-state fault per pin |

## Verification
The bench times each fault to the exact edge. A design that compared the raw or half-synchronised input would flag one or two cycles early, and one that waited for an extra stage would flag late. It returns a pin to its reference to catch a fault that tracks the level instead of holding it. It also clears while a pin is held away from its old reference, which catches a design that forgets to recapture the reference and faults again at once. It lands a clear on the very edge a mismatch would latch, to expose set-over-clear priority. It checks that an output bit of 1 masks blinking and that two blinking pins flip together on each tick.

// File: rtl/opendrain_gpio_pkg.sv
package opendrain_gpio_pkg;

  // Scalar strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic outLoad;    // load output bits
    logic cfgLoad;    // load blink and fault enables
    logic phaseFlip;  // flip the shared blink phase
  } ctrlStrobe_t;

  localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/opendrain_gpio_ctrl.sv
module opendrain_gpio_ctrl
  import opendrain_gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                outWrEn,
  input  logic                cfgWrEn,
  input  logic [NUM_PINS-1:0] cfgFaultEn,
  input  logic                blinkTick,
  input  logic                faultClr,
  input  logic [NUM_PINS-1:0] fltEnQ,
  input  logic [NUM_PINS-1:0] pinSync,
  input  logic [NUM_PINS-1:0] refLevel,
  output ctrlStrobe_t         strobe,
  output logic [NUM_PINS-1:0] capRef,
  output logic [NUM_PINS-1:0] clrFault,
  output logic [NUM_PINS-1:0] setFault
);

  always_comb begin
    strobe.outLoad   = outWrEn;
    strobe.cfgLoad   = cfgWrEn;
    strobe.phaseFlip = blinkTick;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_pinCtl
      logic enRise;
      logic enDrop;
      always_comb begin
        enRise       = cfgWrEn & cfgFaultEn[gi] & ~fltEnQ[gi];
        enDrop       = cfgWrEn & ~cfgFaultEn[gi];
        capRef[gi]   = faultClr | enRise;
        clrFault[gi] = faultClr | enDrop;
        setFault[gi] = fltEnQ[gi] & (pinSync[gi] ^ refLevel[gi]);
      end
    end
  endgenerate

endmodule

// File: rtl/opendrain_gpio_dp.sv
module opendrain_gpio_dp
  import opendrain_gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [NUM_PINS-1:0]   capRef,
  input  logic [NUM_PINS-1:0]   clrFault,
  input  logic [NUM_PINS-1:0]   setFault,
  input  logic [NUM_PINS-1:0]   outWrData,
  input  logic [NUM_PINS-1:0]   cfgBlink,
  input  logic [NUM_PINS-1:0]   cfgFaultEn,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinSync,
  output logic [NUM_PINS-1:0]   refLevel,
  output logic [NUM_PINS-1:0]   fltEnQ,
  output logic                  blinkPhase,
  output logic [NUM_PINS-1:0]   pullDown,
  output logic [2*NUM_PINS-1:0] readback,
  output logic [NUM_PINS-1:0]   faultFlags
);

  localparam int unsigned STAGES = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic [NUM_PINS-1:0] syncChain [STAGES];
  logic [NUM_PINS-1:0] outBits;
  logic [NUM_PINS-1:0] blinkEn;

  // Input synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= '0;
    else       syncChain[0] <= pinIn;
  end

  genvar gs;
  generate
    for (gs = 1; gs < STAGES; gs++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[gs] <= '0;
        else       syncChain[gs] <= syncChain[gs-1];
      end
    end
  endgenerate

  assign pinSync = syncChain[STAGES-1];

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBits <= '1;
      blinkEn <= '0;
      fltEnQ  <= '0;
    end else begin
      if (strobe.outLoad) outBits <= outWrData;
      if (strobe.cfgLoad) begin
        blinkEn <= cfgBlink;
        fltEnQ  <= cfgFaultEn;
      end
    end
  end

  // Shared blink phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 blinkPhase <= 1'b0;
    else if (strobe.phaseFlip) blinkPhase <= ~blinkPhase;
  end

  // Per-pin reference and fault latch, output gating
  genvar gp;
  generate
    for (gp = 0; gp < NUM_PINS; gp++) begin : g_pin
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           refLevel[gp] <= 1'b0;
        else if (capRef[gp]) refLevel[gp] <= pinSync[gp];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             faultFlags[gp] <= 1'b0;
        else if (clrFault[gp]) faultFlags[gp] <= 1'b0;
        else if (setFault[gp]) faultFlags[gp] <= 1'b1;
      end

      always_comb begin
        pullDown[gp] = ~outBits[gp] & (~blinkEn[gp] | blinkPhase);
      end
    end
  endgenerate

  assign readback = {pinSync, outBits};

endmodule

// File: rtl/opendrain_gpio.sv
module opendrain_gpio
  import opendrain_gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  blinkTick,
  input  logic                  outWrEn,
  input  logic [NUM_PINS-1:0]   outWrData,
  input  logic                  cfgWrEn,
  input  logic [NUM_PINS-1:0]   cfgBlink,
  input  logic [NUM_PINS-1:0]   cfgFaultEn,
  input  logic                  faultClr,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pullDown,
  output logic [2*NUM_PINS-1:0] readback,
  output logic [NUM_PINS-1:0]   faultFlags
);

  ctrlStrobe_t         strobe;
  logic [NUM_PINS-1:0] capRef;
  logic [NUM_PINS-1:0] clrFault;
  logic [NUM_PINS-1:0] setFault;
  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] refLevel;
  logic [NUM_PINS-1:0] fltEnQ;
  logic                blinkPhase;

  opendrain_gpio_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .outWrEn    (outWrEn),
    .cfgWrEn    (cfgWrEn),
    .cfgFaultEn (cfgFaultEn),
    .blinkTick  (blinkTick),
    .faultClr   (faultClr),
    .fltEnQ     (fltEnQ),
    .pinSync    (pinSync),
    .refLevel   (refLevel),
    .strobe     (strobe),
    .capRef     (capRef),
    .clrFault   (clrFault),
    .setFault   (setFault)
  );

  opendrain_gpio_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .capRef     (capRef),
    .clrFault   (clrFault),
    .setFault   (setFault),
    .outWrData  (outWrData),
    .cfgBlink   (cfgBlink),
    .cfgFaultEn (cfgFaultEn),
    .pinIn      (pinIn),
    .pinSync    (pinSync),
    .refLevel   (refLevel),
    .fltEnQ     (fltEnQ),
    .blinkPhase (blinkPhase),
    .pullDown   (pullDown),
    .readback   (readback),
    .faultFlags (faultFlags)
  );

endmodule

// File: rtl/opendrain_gpio_chk.sv
module opendrain_gpio_chk #(
  parameter int unsigned NUM_PINS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  blinkTick,
  input logic                  cfgWrEn,
  input logic [NUM_PINS-1:0]   cfgFaultEn,
  input logic                  faultClr,
  input logic [NUM_PINS-1:0]   pullDown,
  input logic [2*NUM_PINS-1:0] readback,
  input logic [NUM_PINS-1:0]   faultFlags,
  input logic [NUM_PINS-1:0]   fltEnQ,
  input logic                  blinkPhase
);

  // R1: leaving reset, no fault and no pull-down
  p_reset_state_r1: assert property (@(posedge clk) !rstN |=> (faultFlags == '0 && pullDown == '0));

  // R4: the shared phase flips on every tick
  p_phase_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    blinkTick |=> (blinkPhase != $past(blinkPhase)));

  // R8: a clear pulse empties every fault flag
  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultClr |=> (faultFlags == '0));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_pinChk
      // R5: released output bit never pulls down
      p_released_r5: assert property (@(posedge clk) disable iff (!rstN)
        readback[gi] |-> !pullDown[gi]);

      // R6: a fault only appears while enabled
      p_needs_en_r6: assert property (@(posedge clk) disable iff (!rstN)
        $rose(faultFlags[gi]) |-> $past(fltEnQ[gi]));

      // R7: a fault holds until a clear or a disable
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
        (faultFlags[gi] && !faultClr && !(cfgWrEn && !cfgFaultEn[gi])) |=> faultFlags[gi]);

      // R9: disabling drops the flag on the next edge
      p_disable_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
        (cfgWrEn && !cfgFaultEn[gi]) |=> !faultFlags[gi]);
    end
  endgenerate

endmodule

bind opendrain_gpio opendrain_gpio_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .blinkTick  (blinkTick),
  .cfgWrEn    (cfgWrEn),
  .cfgFaultEn (cfgFaultEn),
  .faultClr   (faultClr),
  .pullDown   (pullDown),
  .readback   (readback),
  .faultFlags (faultFlags),
  .fltEnQ     (fltEnQ),
  .blinkPhase (blinkPhase)
);

// File: tb/opendrain_gpio_tb.sv
module opendrain_gpio_tb;

  localparam int unsigned N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         blinkTick = 1'b0;
  logic         outWrEn = 1'b0;
  logic [N-1:0] outWrData = '0;
  logic         cfgWrEn = 1'b0;
  logic [N-1:0] cfgBlink = '0;
  logic [N-1:0] cfgFaultEn = '0;
  logic         faultClr = 1'b0;
  logic [N-1:0] pinIn = '0;
  logic [N-1:0] pullDown;
  logic [2*N-1:0] readback;
  logic [N-1:0] faultFlags;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [N-1:0] expOut = '1;
  logic [N-1:0] expBlink = '0;
  logic expPhase = 1'b0;

  always #10 clk = ~clk;

  opendrain_gpio #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rstN(rstN), .blinkTick(blinkTick), .outWrEn(outWrEn),
    .outWrData(outWrData), .cfgWrEn(cfgWrEn), .cfgBlink(cfgBlink),
    .cfgFaultEn(cfgFaultEn), .faultClr(faultClr), .pinIn(pinIn),
    .pullDown(pullDown), .readback(readback), .faultFlags(faultFlags)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic writeOut(input logic [N-1:0] v);
    outWrData = v; outWrEn = 1'b1; cyc(1); outWrEn = 1'b0; expOut = v;
  endtask

  task automatic writeCfg(input logic [N-1:0] b, input logic [N-1:0] f);
    cfgBlink = b; cfgFaultEn = f; cfgWrEn = 1'b1; cyc(1); cfgWrEn = 1'b0; expBlink = b;
  endtask

  task automatic tick();
    blinkTick = 1'b1; cyc(1); blinkTick = 1'b0; expPhase = ~expPhase;
  endtask

  task automatic pulseClr();
    faultClr = 1'b1; cyc(1); faultClr = 1'b0;
  endtask

  function automatic logic [N-1:0] expPd();
    return ~expOut & (~expBlink | {N{expPhase}});
  endfunction

  task automatic t_reset();
    chk("R1", "pullDown", 8'(pullDown), 8'h0);
    chk("R1", "faultFlags", 8'(faultFlags), 8'h0);
    chk("R1", "readback", readback, 8'h0F);
  endtask

  task automatic t_output();
    writeOut(4'b1010);
    chk("R2", "pullDown", 8'(pullDown), 8'h05);
    chk("R3", "readback low", readback, 8'h0A);
    writeOut(4'b0011);
    chk("R2", "pullDown", 8'(pullDown), 8'h0C);
  endtask

  task automatic t_sync();
    pinIn = 4'b0110;
    cyc(1);
    chk("R3", "readback after 1 edge", readback, 8'h03);
    cyc(1);
    chk("R3", "readback after 2 edges", readback, 8'h63);
    pinIn = 4'b0000; cyc(2);
  endtask

  task automatic t_blink();
    writeOut(4'b0000);
    writeCfg(4'b0011, 4'b0000);
    chk("R4", "pullDown phase a", 8'(pullDown), 8'(expPd()));
    tick();
    chk("R4", "pullDown phase b", 8'(pullDown), 8'(expPd()));
    tick();
    chk("R4", "pullDown phase c", 8'(pullDown), 8'(expPd()));
    tick();
    chk("R4", "two pins in step", 8'(pullDown[1:0]), {6'd0, {2{expPhase}}});
  endtask

  task automatic t_mask();
    writeOut(4'b1111);
    writeCfg(4'b1111, 4'b0000);
    chk("R5", "pullDown masked", 8'(pullDown), 8'h0);
    tick();
    chk("R5", "pullDown masked other phase", 8'(pullDown), 8'h0);
    writeCfg(4'b0000, 4'b0000);
  endtask

  task automatic t_faultSet();
    pinIn = 4'b0000; cyc(3);
    writeCfg(4'b0000, 4'b1111);
    pinIn[2] = 1'b1;
    cyc(2);
    chk("R6", "no fault after 2 edges", 8'(faultFlags), 8'h0);
    cyc(1);
    chk("R6", "fault on 3rd edge", 8'(faultFlags), 8'h04);
    pinIn[2] = 1'b0; cyc(4);
    chk("R7", "fault held", 8'(faultFlags), 8'h04);
  endtask

  task automatic t_clear();
    pinIn = 4'b0010; cyc(3);
    chk("R6", "second pin faults", 8'(faultFlags), 8'h06);
    pulseClr();
    chk("R8", "cleared", 8'(faultFlags), 8'h0);
    cyc(4);
    chk("R8", "held level is new reference", 8'(faultFlags), 8'h0);
    pinIn = 4'b0000; cyc(3);
    chk("R8", "refault from captured level", 8'(faultFlags), 8'h02);
  endtask

  task automatic t_disable();
    writeCfg(4'b0000, 4'b1101);
    chk("R9", "disable clears", 8'(faultFlags), 8'h0);
    pinIn[1] = 1'b1; cyc(4);
    pinIn[1] = 1'b0; cyc(4);
    chk("R9", "no fault while disabled", 8'(faultFlags), 8'h0);
  endtask

  task automatic t_race();
    writeCfg(4'b0000, 4'b1111);
    pinIn[3] = 1'b1;
    cyc(2);
    pulseClr();
    chk("R10", "clear wins", 8'(faultFlags), 8'h0);
    cyc(4);
    chk("R10", "no later fault", 8'(faultFlags), 8'h0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    t_reset();
    t_output();
    t_sync();
    t_blink();
    t_mask();
    t_faultSet();
    t_clear();
    t_disable();
    t_race();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

endmodule